// File: doc/BRIEF.md
# Raster Timing Generator with Line, Pixel and Frame Counters

This block produces horizontal and vertical video timing, one pixel per clock, from a set of programmed totals and blanking and sync boundaries. Alongside the timing levels it keeps a scanline counter, a pixel-in-frame counter and two 24-bit frame counters. One frame counter advances at the start of vertical blanking. The other advances when the first active pixel of a new frame is presented.

Three single-cycle event pulses mark the start of vertical blanking, the start of vertical sync and a frame-start point that lags blanking by a programmable number of lines. Vertical events are placed on the first pixel of horizontal sync, not on the start of a line. At the start-of-blanking event the block copies a bank of staged shadow values into their live copies and captures an external free-running timestamp. The scanline counter can be read in three offset conventions, so that software written for different counter behaviours sees the values it expects.

Timing inputs are held static while `en` is high. A legal configuration has hblank_start <= hsync_start < htotal, 1 <= vblank_start, vblank_start + 3 < vtotal, and vblank_start < vsync_start < vsync_end <= vblank_end <= vtotal. All outputs are registered and show pixel k of the run k+1 clocks after the first enabled edge.

Top module: `disp_timing_gen`

## Requirements
- R1: The horizontal position runs 0..htotal-1 and the line runs 0..vtotal-1. `hblank_o` is high when the position is >= hblank_start and `hsync_o` is high when it is >= hsync_start. `active_o` is high when the position is < hblank_start and the line is < vblank_start.
- R2: `ev_vblank_start_o` pulses for one cycle on the hsync_start pixel of line vblank_start-1. `vblank_o` rises on that pixel and falls on the hsync_start pixel of line vblank_end-1 (modulo vtotal), so vertical levels switch at sync start.
- R3: `ev_frame_start_o` pulses on the hblank_start pixel of line vblank_start+fs_delay, which is 1 to 4 lines after the start of blanking for fs_delay 0 to 3.
- R4: `ev_vsync_start_o` pulses on the hsync_start pixel of line vsync_start-1. `vsync_o` stays high from that pixel until the hsync_start pixel of line vsync_end-1.
- R5: The scanline counter steps at the first pixel of horizontal sync. With sl_mode 0 it reads vtotal-1 on line 0 before sync and vblank_start-1 right after the start-of-blanking event.
- R6: With sl_mode 1 the scanline reads two above mode 0, modulo vtotal, so it reads vblank_start+1 after the start of blanking. With sl_mode 2 it reads one below mode 0. sl_mode 3 reads as mode 0.
- R7: `pixel_o` equals line*htotal + position. It is 0 on the first active pixel and vblank_start*htotal on the first pixel of the first blanking line.
- R8: `frame_pix_o` (24 bits, wrapping modulo 2^24) increments when pixel 0 of each later frame is presented. It does not increment for the first frame after enable.
- R9: `frame_vbl_o` (24 bits, wrapping) increments in the same cycle that `ev_vblank_start_o` is high.
- R10: The shadow slots are copied into `shadow_act_o` in the cycle of `ev_vblank_start_o`. A change of `shadow_in` at any other time has no effect on `shadow_act_o`.
- R11: `frame_ts_o` captures `ts_now` at the start-of-blanking event and holds that value until the next such event.
- R12: While `en` is low, all counters, levels and events read 0 from the next cycle on, while shadow and timestamp copies keep their values. Raising `en` restarts the run at pixel 0 of line 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Generator enable |
| sl_mode | input | 2 | Scanline offset convention (0 standard, 1 two ahead, 2 one behind, 3 standard) |
| fs_delay | input | 2 | Extra lines from blanking start to frame start |
| htotal | input | HW | Pixels per line |
| hblank_start | input | HW | First horizontal blanking pixel |
| hsync_start | input | HW | First horizontal sync pixel |
| vtotal | input | VW | Lines per frame |
| vblank_start | input | VW | First vertical blanking line |
| vblank_end | input | VW | Line after the last blanking line |
| vsync_start | input | VW | First vertical sync line |
| vsync_end | input | VW | Line after the last sync line |
| shadow_in | input | NSH*SHW | Staged shadow values |
| ts_now | input | TSW | Free-running timestamp |
| hblank_o | output | 1 | Horizontal blanking level |
| hsync_o | output | 1 | Horizontal sync level |
| vblank_o | output | 1 | Vertical blanking level |
| vsync_o | output | 1 | Vertical sync level |
| active_o | output | 1 | Active picture pixel |
| scanline_o | output | VW | Scanline counter in the selected convention |
| pixel_o | output | HW+VW | Pixel index within the frame |
| frame_vbl_o | output | FCW | Frame count stepped at blanking start |
| frame_pix_o | output | FCW | Frame count stepped at first active pixel |
| ev_vblank_start_o | output | 1 | Start-of-blanking pulse |
| ev_frame_start_o | output | 1 | Frame-start pulse |
| ev_vsync_start_o | output | 1 | Start-of-sync pulse |
| shadow_act_o | output | NSH*SHW | Live copies of the shadow slots |
| frame_ts_o | output | TSW | Timestamp captured at blanking start |

## Verification
The assertions check relations that must hold on every cycle. The horizontal position never reaches htotal. Each start-of-blanking or start-of-sync pulse coincides with a rising edge of its level. Frame start falls inside both blankings. Both frame counters step by exactly one on their triggers, and the shadow copies hold between events. Dropping the enable empties every counter and event. Only the bench's scenarios can show that the events fall on the exact pixel and line. The same holds for the absolute scanline value in each offset convention, the effect of each fs_delay setting, and the frame count after several frames.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  typedef enum logic [1:0] {
    SL_STD    = 2'd0,
    SL_AHEAD  = 2'd1,
    SL_BEHIND = 2'd2,
    SL_RSVD   = 2'd3
  } sl_mode_e;
endpackage

// File: rtl/dtg_hv_counter.sv
module dtg_hv_counter #(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [HW-1:0]     htotal,
  input  logic [VW-1:0]     vtotal,
  output logic [HW-1:0]     hc,
  output logic [VW-1:0]     vc,
  output logic [HW+VW-1:0]  pix,
  output logic              frame_end
);
  localparam int PW = HW + VW;

  logic line_end;

  assign line_end  = (hc == htotal - HW'(1));
  assign frame_end = en && line_end && (vc == vtotal - VW'(1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hc  <= '0;
      vc  <= '0;
      pix <= '0;
    end else if (line_end) begin
      hc <= '0;
      if (vc == vtotal - VW'(1)) begin
        vc  <= '0;
        pix <= '0;
      end else begin
        vc  <= vc + VW'(1);
        pix <= pix + PW'(1);
      end
    end else begin
      hc  <= hc + HW'(1);
      pix <= pix + PW'(1);
    end
  end

  // R1: horizontal position stays below the programmed total
  a_r1_hc_range: assert property (@(posedge clk) disable iff (rst || !en)
    hc < htotal);
  // R1: line number stays below the programmed total
  a_r1_vc_range: assert property (@(posedge clk) disable iff (rst || !en)
    vc < vtotal);
endmodule

// File: rtl/dtg_event_gen.sv
module dtg_event_gen
  import dtg_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  sl_mode_e          sl_mode,
  input  logic [1:0]        fs_delay,
  input  logic [HW-1:0]     hblank_start,
  input  logic [HW-1:0]     hsync_start,
  input  logic [VW-1:0]     vtotal,
  input  logic [VW-1:0]     vblank_start,
  input  logic [VW-1:0]     vblank_end,
  input  logic [VW-1:0]     vsync_start,
  input  logic [VW-1:0]     vsync_end,
  input  logic [HW-1:0]     hc,
  input  logic [VW-1:0]     vc,
  input  logic [HW+VW-1:0]  pix,
  output logic              vbs_hit,
  output logic              hblank_o,
  output logic              hsync_o,
  output logic              vblank_o,
  output logic              vsync_o,
  output logic              active_o,
  output logic [VW-1:0]     scanline_o,
  output logic [HW+VW-1:0]  pixel_o,
  output logic              ev_vblank_start_o,
  output logic              ev_frame_start_o,
  output logic              ev_vsync_start_o
);
  logic          at_hs, at_hb, past_hs;
  logic [VW-1:0] vbs_prev, vss_prev, t_next, tline, sl_val;
  logic [VW:0]   fs_line;
  logic          vss_hit, fs_hit, vbl_lvl, vs_lvl, act_lvl;

  assign at_hs   = (hc == hsync_start);
  assign at_hb   = (hc == hblank_start);
  assign past_hs = (hc >= hsync_start);

  // vertical events sit on the sync pixel of the line before their boundary
  assign vbs_prev = (vblank_start == '0) ? vtotal - VW'(1) : vblank_start - VW'(1);
  assign vss_prev = (vsync_start  == '0) ? vtotal - VW'(1) : vsync_start  - VW'(1);
  assign fs_line  = {1'b0, vblank_start} + {{(VW-1){1'b0}}, fs_delay};

  assign vbs_hit = en && at_hs && (vc == vbs_prev);
  assign vss_hit = en && at_hs && (vc == vss_prev);
  assign fs_hit  = en && at_hb && ({1'b0, vc} == fs_line);

  // line count as seen by sync-aligned logic
  assign t_next = (vc == vtotal - VW'(1)) ? '0 : vc + VW'(1);
  assign tline  = past_hs ? t_next : vc;

  assign vbl_lvl = (tline >= vblank_start) && (tline < vblank_end);
  assign vs_lvl  = (tline >= vsync_start) && (tline < vsync_end);
  assign act_lvl = (hc < hblank_start) && (vc < vblank_start);

  always_comb begin
    case (sl_mode)
      SL_AHEAD:  sl_val = (tline == vtotal - VW'(1)) ? '0 : tline + VW'(1);
      SL_BEHIND: sl_val = (tline >= VW'(2)) ? tline - VW'(2) : tline + vtotal - VW'(2);
      default:   sl_val = (tline == '0) ? vtotal - VW'(1) : tline - VW'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hblank_o          <= 1'b0;
      hsync_o           <= 1'b0;
      vblank_o          <= 1'b0;
      vsync_o           <= 1'b0;
      active_o          <= 1'b0;
      scanline_o        <= '0;
      pixel_o           <= '0;
      ev_vblank_start_o <= 1'b0;
      ev_frame_start_o  <= 1'b0;
      ev_vsync_start_o  <= 1'b0;
    end else begin
      hblank_o          <= (hc >= hblank_start);
      hsync_o           <= past_hs;
      vblank_o          <= vbl_lvl;
      vsync_o           <= vs_lvl;
      active_o          <= act_lvl;
      scanline_o        <= sl_val;
      pixel_o           <= pix;
      ev_vblank_start_o <= vbs_hit;
      ev_frame_start_o  <= fs_hit;
      ev_vsync_start_o  <= vss_hit;
    end
  end

  // R2: blanking-start pulse marks the rising edge of the blanking level
  a_r2_vbl_rise: assert property (@(posedge clk) disable iff (rst)
    ev_vblank_start_o |-> (vblank_o && !$past(vblank_o)));
  // R4: sync-start pulse marks the rising edge of the sync level
  a_r4_vs_rise: assert property (@(posedge clk) disable iff (rst)
    ev_vsync_start_o |-> (vsync_o && !$past(vsync_o)));
  // R3: frame start lies inside both blankings, never with blanking start
  a_r3_fs_in_blank: assert property (@(posedge clk) disable iff (rst)
    ev_frame_start_o |-> (vblank_o && hblank_o && !ev_vblank_start_o));
  // R12: disabling empties levels, counters and events on the next cycle
  a_r12_idle: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!ev_vblank_start_o && !ev_frame_start_o && !ev_vsync_start_o &&
             !vblank_o && !active_o && scanline_o == '0 && pixel_o == '0));
endmodule

// File: rtl/dtg_frame_state.sv
module dtg_frame_state #(
  parameter int FCW = 24,
  parameter int NSH = 4,
  parameter int SHW = 16,
  parameter int TSW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               vbs_hit,
  input  logic               frame_end,
  input  logic [NSH*SHW-1:0] shadow_in,
  input  logic [TSW-1:0]     ts_now,
  output logic [FCW-1:0]     frame_vbl_o,
  output logic [FCW-1:0]     frame_pix_o,
  output logic [NSH*SHW-1:0] shadow_act_o,
  output logic [TSW-1:0]     frame_ts_o
);
  logic wrap_d;

  // wrap_d aligns the pixel-based count with the presented first pixel
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wrap_d      <= 1'b0;
      frame_vbl_o <= '0;
      frame_pix_o <= '0;
    end else begin
      wrap_d <= frame_end;
      if (vbs_hit) frame_vbl_o <= frame_vbl_o + FCW'(1);
      if (wrap_d)  frame_pix_o <= frame_pix_o + FCW'(1);
    end
  end

  for (genvar g = 0; g < NSH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) shadow_act_o[g*SHW +: SHW] <= '0;
      else if (vbs_hit) shadow_act_o[g*SHW +: SHW] <= shadow_in[g*SHW +: SHW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) frame_ts_o <= '0;
    else if (vbs_hit) frame_ts_o <= ts_now;
  end

  // R9: blanking-based frame count steps by one on each event
  a_r9_fvbl_step: assert property (@(posedge clk) disable iff (rst)
    vbs_hit |=> (frame_vbl_o == $past(frame_vbl_o) + FCW'(1)));
  // R8: pixel-based frame count steps by one after each frame wrap
  a_r8_fpix_step: assert property (@(posedge clk) disable iff (rst)
    (wrap_d && en) |=> (frame_pix_o == $past(frame_pix_o) + FCW'(1)));
  // R10: live shadow copies only move on a blanking-start event
  a_r10_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    !vbs_hit |=> $stable(shadow_act_o));
  // R11: timestamp copy only moves on a blanking-start event
  a_r11_ts_hold: assert property (@(posedge clk) disable iff (rst)
    !vbs_hit |=> $stable(frame_ts_o));
endmodule

// File: rtl/disp_timing_gen.sv
module disp_timing_gen
  import dtg_pkg::*;
#(
  parameter int HW  = 12,
  parameter int VW  = 12,
  parameter int FCW = 24,
  parameter int NSH = 4,
  parameter int SHW = 16,
  parameter int TSW = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic [1:0]         sl_mode,
  input  logic [1:0]         fs_delay,
  input  logic [HW-1:0]      htotal,
  input  logic [HW-1:0]      hblank_start,
  input  logic [HW-1:0]      hsync_start,
  input  logic [VW-1:0]      vtotal,
  input  logic [VW-1:0]      vblank_start,
  input  logic [VW-1:0]      vblank_end,
  input  logic [VW-1:0]      vsync_start,
  input  logic [VW-1:0]      vsync_end,
  input  logic [NSH*SHW-1:0] shadow_in,
  input  logic [TSW-1:0]     ts_now,
  output logic               hblank_o,
  output logic               hsync_o,
  output logic               vblank_o,
  output logic               vsync_o,
  output logic               active_o,
  output logic [VW-1:0]      scanline_o,
  output logic [HW+VW-1:0]   pixel_o,
  output logic [FCW-1:0]     frame_vbl_o,
  output logic [FCW-1:0]     frame_pix_o,
  output logic               ev_vblank_start_o,
  output logic               ev_frame_start_o,
  output logic               ev_vsync_start_o,
  output logic [NSH*SHW-1:0] shadow_act_o,
  output logic [TSW-1:0]     frame_ts_o
);
  localparam int PW = HW + VW;

  logic [HW-1:0] hc;
  logic [VW-1:0] vc;
  logic [PW-1:0] pix;
  logic          frame_end, vbs_hit;
  sl_mode_e      mode;

  assign mode = sl_mode_e'(sl_mode);

  dtg_hv_counter #(.HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .htotal(htotal), .vtotal(vtotal),
    .hc(hc), .vc(vc), .pix(pix), .frame_end(frame_end)
  );

  dtg_event_gen #(.HW(HW), .VW(VW)) u_evt (
    .clk(clk), .rst(rst), .en(en), .sl_mode(mode), .fs_delay(fs_delay),
    .hblank_start(hblank_start), .hsync_start(hsync_start), .vtotal(vtotal),
    .vblank_start(vblank_start), .vblank_end(vblank_end),
    .vsync_start(vsync_start), .vsync_end(vsync_end),
    .hc(hc), .vc(vc), .pix(pix), .vbs_hit(vbs_hit),
    .hblank_o(hblank_o), .hsync_o(hsync_o), .vblank_o(vblank_o),
    .vsync_o(vsync_o), .active_o(active_o), .scanline_o(scanline_o),
    .pixel_o(pixel_o), .ev_vblank_start_o(ev_vblank_start_o),
    .ev_frame_start_o(ev_frame_start_o), .ev_vsync_start_o(ev_vsync_start_o)
  );

  dtg_frame_state #(.FCW(FCW), .NSH(NSH), .SHW(SHW), .TSW(TSW)) u_frm (
    .clk(clk), .rst(rst), .en(en), .vbs_hit(vbs_hit), .frame_end(frame_end),
    .shadow_in(shadow_in), .ts_now(ts_now), .frame_vbl_o(frame_vbl_o),
    .frame_pix_o(frame_pix_o), .shadow_act_o(shadow_act_o), .frame_ts_o(frame_ts_o)
  );
endmodule

// File: tb/tb_disp_timing_gen.sv
`timescale 1ns/1ps
module tb_disp_timing_gen;
  localparam int HW = 12, VW = 12, FCW = 24, NSH = 4, SHW = 16, TSW = 32;
  localparam int HT = 10, VT = 12, FR = HT * VT;

  logic clk = 1'b0, rst = 1'b1, en = 1'b0;
  logic [1:0] sl_mode = 2'd0, fs_delay = 2'd0;
  logic [NSH*SHW-1:0] shadow_in = '0;
  logic [TSW-1:0] ts_now = '0;
  logic hblank_o, hsync_o, vblank_o, vsync_o, active_o;
  logic [VW-1:0] scanline_o;
  logic [HW+VW-1:0] pixel_o;
  logic [FCW-1:0] frame_vbl_o, frame_pix_o;
  logic ev_vblank_start_o, ev_frame_start_o, ev_vsync_start_o;
  logic [NSH*SHW-1:0] shadow_act_o;
  logic [TSW-1:0] frame_ts_o;

  always #4 clk = ~clk;

  disp_timing_gen #(.HW(HW), .VW(VW), .FCW(FCW), .NSH(NSH), .SHW(SHW), .TSW(TSW)) dut (
    .clk(clk), .rst(rst), .en(en), .sl_mode(sl_mode), .fs_delay(fs_delay),
    .htotal(12'd10), .hblank_start(12'd6), .hsync_start(12'd8),
    .vtotal(12'd12), .vblank_start(12'd5), .vblank_end(12'd12),
    .vsync_start(12'd7), .vsync_end(12'd9),
    .shadow_in(shadow_in), .ts_now(ts_now),
    .hblank_o(hblank_o), .hsync_o(hsync_o), .vblank_o(vblank_o), .vsync_o(vsync_o),
    .active_o(active_o), .scanline_o(scanline_o), .pixel_o(pixel_o),
    .frame_vbl_o(frame_vbl_o), .frame_pix_o(frame_pix_o),
    .ev_vblank_start_o(ev_vblank_start_o), .ev_frame_start_o(ev_frame_start_o),
    .ev_vsync_start_o(ev_vsync_start_o), .shadow_act_o(shadow_act_o),
    .frame_ts_o(frame_ts_o)
  );

  typedef struct packed {
    int unsigned p; int unsigned sl;
    bit vbl; bit vs; bit act; bit evb; bit evf; bit evs;
  } vec_t;

  // timing: htotal 10, hblank 6, hsync 8, vtotal 12, vblank 5..12, vsync 7..9
  localparam vec_t VEC [13] = '{
    '{p:0,   sl:11, vbl:0, vs:0, act:1, evb:0, evf:0, evs:0},
    '{p:8,   sl:0,  vbl:0, vs:0, act:0, evb:0, evf:0, evs:0},
    '{p:47,  sl:3,  vbl:0, vs:0, act:0, evb:0, evf:0, evs:0},
    '{p:48,  sl:4,  vbl:1, vs:0, act:0, evb:1, evf:0, evs:0},
    '{p:50,  sl:4,  vbl:1, vs:0, act:0, evb:0, evf:0, evs:0},
    '{p:56,  sl:4,  vbl:1, vs:0, act:0, evb:0, evf:1, evs:0},
    '{p:67,  sl:5,  vbl:1, vs:0, act:0, evb:0, evf:0, evs:0},
    '{p:68,  sl:6,  vbl:1, vs:1, act:0, evb:0, evf:0, evs:1},
    '{p:87,  sl:7,  vbl:1, vs:1, act:0, evb:0, evf:0, evs:0},
    '{p:88,  sl:8,  vbl:1, vs:0, act:0, evb:0, evf:0, evs:0},
    '{p:117, sl:10, vbl:1, vs:0, act:0, evb:0, evf:0, evs:0},
    '{p:118, sl:11, vbl:0, vs:0, act:0, evb:0, evf:0, evs:0},
    '{p:121, sl:11, vbl:0, vs:0, act:1, evb:0, evf:0, evs:0}
  };

  int n_run = 0, n_fail = 0, pidx = 0;
  bit done = 1'b0;

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at pixel %0d: got %0h expected %0h", req, pidx, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); pidx++; @(negedge clk);
  endtask

  task automatic start();
    @(negedge clk); en = 1'b1;
    @(posedge clk); pidx = 0; @(negedge clk);
  endtask

  task automatic stop();
    en = 1'b0; @(posedge clk); @(negedge clk);
  endtask

  task automatic goto(input int p);
    while (pidx < p) step();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk("R12 reset scanline", 64'(scanline_o), 64'd0);
    chk("R12 reset vblank", 64'(vblank_o), 64'd0);
    chk("R12 reset shadow", 64'(shadow_act_o), 64'd0);
    rst = 1'b0;
    shadow_in = 64'h1111_2222_3333_4444;
    ts_now = 32'h0000_00AA;
    start();
    foreach (VEC[i]) begin
      goto(int'(VEC[i].p));
      chk("R5 scanline", 64'(scanline_o), 64'(VEC[i].sl));
      chk("R2 vblank", 64'(vblank_o), 64'(VEC[i].vbl));
      chk("R4 vsync", 64'(vsync_o), 64'(VEC[i].vs));
      chk("R1 active", 64'(active_o), 64'(VEC[i].act));
      chk("R2 ev_vblank_start", 64'(ev_vblank_start_o), 64'(VEC[i].evb));
      chk("R3 ev_frame_start", 64'(ev_frame_start_o), 64'(VEC[i].evf));
      chk("R4 ev_vsync_start", 64'(ev_vsync_start_o), 64'(VEC[i].evs));
      chk("R7 pixel", 64'(pixel_o), 64'(VEC[i].p % FR));
      chk("R1 hblank", 64'(hblank_o), 64'((VEC[i].p % HT) >= 6));
      chk("R1 hsync", 64'(hsync_o), 64'((VEC[i].p % HT) >= 8));
      if (VEC[i].p == 47) begin
        chk("R10 shadow before event", 64'(shadow_act_o), 64'd0);
        chk("R9 frame_vbl before", 64'(frame_vbl_o), 64'd0);
      end
      if (VEC[i].p == 48) begin
        chk("R10 shadow latched", 64'(shadow_act_o), 64'h1111_2222_3333_4444);
        chk("R11 timestamp", 64'(frame_ts_o), 64'hAA);
        chk("R9 frame_vbl", 64'(frame_vbl_o), 64'd1);
        chk("R7 blank start pixel", 64'(pixel_o), 64'd48);
      end
      if (VEC[i].p == 50) chk("R7 first blank line", 64'(pixel_o), 64'd50);
      if (VEC[i].p == 56) begin
        // R10: staged value changes outside the event are ignored
        shadow_in = 64'hDEAD_BEEF_0000_5555;
        ts_now = 32'h0000_00BB;
      end
      if (VEC[i].p == 118) begin
        chk("R10 shadow held", 64'(shadow_act_o), 64'h1111_2222_3333_4444);
        chk("R11 timestamp held", 64'(frame_ts_o), 64'hAA);
        chk("R8 frame_pix first frame", 64'(frame_pix_o), 64'd0);
      end
      if (VEC[i].p == 121) chk("R8 frame_pix", 64'(frame_pix_o), 64'd1);
    end
    goto(FR + 48);
    chk("R10 shadow next event", 64'(shadow_act_o), 64'hDEAD_BEEF_0000_5555);
    chk("R11 timestamp next", 64'(frame_ts_o), 64'hBB);
    goto(3 * FR + 48);
    chk("R9 frame_vbl multi", 64'(frame_vbl_o), 64'd4);
    chk("R8 frame_pix multi", 64'(frame_pix_o), 64'd3);

    // R12: disable clears counters and events but keeps shadow copies
    stop();
    chk("R12 idle pixel", 64'(pixel_o), 64'd0);
    chk("R12 idle frame_vbl", 64'(frame_vbl_o), 64'd0);
    chk("R12 idle frame_pix", 64'(frame_pix_o), 64'd0);
    chk("R12 idle scanline", 64'(scanline_o), 64'd0);
    chk("R12 shadow kept", 64'(shadow_act_o), 64'hDEAD_BEEF_0000_5555);

    // R6: offset conventions
    sl_mode = 2'd1; start();
    chk("R6 ahead line0", 64'(scanline_o), 64'd1);
    goto(48); chk("R6 ahead vbl", 64'(scanline_o), 64'd6);
    stop(); sl_mode = 2'd2; start();
    chk("R6 behind line0", 64'(scanline_o), 64'd10);
    goto(48); chk("R6 behind vbl", 64'(scanline_o), 64'd3);
    stop(); sl_mode = 2'd3; start();
    goto(48); chk("R6 reserved as std", 64'(scanline_o), 64'd4);
    stop(); sl_mode = 2'd0;

    // R3: frame start lag of four lines
    fs_delay = 2'd3; start();
    goto(56); chk("R3 no fs at line 5", 64'(ev_frame_start_o), 64'd0);
    goto(85); chk("R3 fs not early", 64'(ev_frame_start_o), 64'd0);
    goto(86); chk("R3 fs at line 8", 64'(ev_frame_start_o), 64'd1);
    goto(87); chk("R3 fs one cycle", 64'(ev_frame_start_o), 64'd0);
    stop();
    fs_delay = 2'd1; start();
    goto(66); chk("R3 fs delay1", 64'(ev_frame_start_o), 64'd1);
    stop();

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule